// File: doc/BRIEF.md
# Event-Programmable PWM Waveform Generator

This block turns the event pulses of an external PWM timebase into two pulse-width-modulated outputs, A and B. The timebase supplies single-cycle pulses for "counter at zero", "counter at load value", "counter equals compare A" and "counter equals compare B", plus a flag for the current count direction. Each output owns a configuration word. The word holds one 2-bit action per direction-qualified event. The action says whether that event leaves the output alone, inverts it, forces it low or forces it high.

In up/down counting mode, a compare match splits into an up event and a down event according to the direction flag. This allows center-aligned pulses, for example by going high on the compare-A up match and low on the compare-A down match. In down-only mode, every compare match counts as a down event. This mode gives left- or right-aligned pulses. When several events arrive in the same cycle, a fixed priority chooses the action that applies. Both outputs are registered.

Top module: `pwm_evgen`

## Requirements
- R1: While `rst_n` is low, both outputs are low, and reset acts without waiting for a clock edge.
- R2: Action codes are 00 = keep the current level, 01 = invert it, 10 = drive low, 11 = drive high.
- R3: Each configuration word holds six 2-bit fields. From bit 0 upward they are: zero [1:0], load [3:2], compare-A up [5:4], compare-A down [7:6], compare-B up [9:8], compare-B down [11:10].
- R4: With `mode_updown`=1, a compare pulse uses its up field when `dir_up`=1 and its down field when `dir_up`=0.
- R5: With `mode_updown`=0, a compare pulse always uses its down field, whatever `dir_up` is, and the up fields have no effect.
- R6: Output A follows only `cfg_a` and output B follows only `cfg_b`. Each word has fields for all six events.
- R7: When events coincide, a compare event outranks load, and load outranks zero. Between the two compares, compare A outranks compare B when `CMPB_FIRST`=0.
- R8: An event whose code is 00 takes no part in the priority choice, so a lower-ranked event that is active in the same cycle still applies its action.
- R9: An output takes its new value at the clock edge that samples the event. With no event pulse, the output holds its level.
- R10: In up/down mode, with A set to high on compare-A up and low on compare-A down, the output is high for an equal span on each side of the load point. With load 7 and compare 3, it is high for 8 of every 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_updown | input | 1 | 1 = up/down counting, 0 = down-only |
| dir_up | input | 1 | Count direction from the timebase, 1 = counting up |
| evt_zero | input | 1 | Pulse: counter at zero |
| evt_load | input | 1 | Pulse: counter at load value |
| evt_cmpa | input | 1 | Pulse: counter equals compare A |
| evt_cmpb | input | 1 | Pulse: counter equals compare B |
| cfg_a | input | 12 | Action word for output A |
| cfg_b | input | 12 | Action word for output B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The hardest cases to reach are coincident events. In these cases the priority order and the rule that a 00 code drops out of the choice decide the result. A normal timebase rarely produces them, except when a compare value equals zero or the load value. The vector table drives zero, load and both compares together in chosen combinations. Each combination uses action words in which the winning and the losing events would leave the output at different levels. A free-running up/down counter model in the bench then produces a center-aligned waveform, and the bench checks it cycle by cycle.

// File: rtl/pwm_evgen_pkg.sv
package pwm_evgen_pkg;
   localparam int unsigned ACT_W   = 2;
   localparam int unsigned NUM_EVT = 6;
   localparam int unsigned CFG_W   = ACT_W * NUM_EVT;
   localparam int unsigned NUM_OUT = 2;

   // event slots, which are also field positions inside an action word
   localparam int unsigned EV_ZERO = 0;
   localparam int unsigned EV_LOAD = 1;
   localparam int unsigned EV_AUP  = 2;
   localparam int unsigned EV_ADN  = 3;
   localparam int unsigned EV_BUP  = 4;
   localparam int unsigned EV_BDN  = 5;

   typedef enum logic [ACT_W-1:0] {
      ACT_KEEP = 2'b00,
      ACT_FLIP = 2'b01,
      ACT_LOW  = 2'b10,
      ACT_HIGH = 2'b11
   } act_e;

   typedef logic [NUM_EVT-1:0] evt_vec_t;
   typedef logic [CFG_W-1:0]   cfg_t;
endpackage

// File: rtl/pwm_evgen_qual.sv
module pwm_evgen_qual
   import pwm_evgen_pkg::*;
(
   input  logic     mode_updown,
   input  logic     dir_up,
   input  logic     evt_zero,
   input  logic     evt_load,
   input  logic     evt_cmpa,
   input  logic     evt_cmpb,
   output evt_vec_t evts
);
   logic going_up;

   // down-only mode never reports an up-direction compare
   assign going_up = mode_updown & dir_up;

   always_comb begin
      evts          = '0;
      evts[EV_ZERO] = evt_zero;
      evts[EV_LOAD] = evt_load;
      evts[EV_AUP]  = evt_cmpa &  going_up;
      evts[EV_ADN]  = evt_cmpa & ~going_up;
      evts[EV_BUP]  = evt_cmpb &  going_up;
      evts[EV_BDN]  = evt_cmpb & ~going_up;
   end
endmodule

// File: rtl/pwm_evgen_chan.sv
module pwm_evgen_chan
   import pwm_evgen_pkg::*;
#(
   parameter bit CMPB_FIRST = 1'b0
)(
   input  logic     clk,
   input  logic     rst_n,
   input  evt_vec_t evts,
   input  cfg_t     cfg,
   output logic     level
);
   // scan order from lowest to highest rank, the last hit wins
   localparam int unsigned ORD_A [NUM_EVT] =
      '{EV_ZERO, EV_LOAD, EV_BUP, EV_BDN, EV_AUP, EV_ADN};
   localparam int unsigned ORD_B [NUM_EVT] =
      '{EV_ZERO, EV_LOAD, EV_AUP, EV_ADN, EV_BUP, EV_BDN};

   logic [ACT_W-1:0] win_code;
   logic             level_nxt;

   generate
      if (CMPB_FIRST) begin : g_bfirst
         always_comb begin
            win_code = ACT_KEEP;
            for (int i = 0; i < NUM_EVT; i++) begin
               if (evts[ORD_B[i]] && (cfg[ACT_W*ORD_B[i] +: ACT_W] != ACT_KEEP))
                  win_code = cfg[ACT_W*ORD_B[i] +: ACT_W];
            end
         end
      end else begin : g_afirst
         always_comb begin
            win_code = ACT_KEEP;
            for (int i = 0; i < NUM_EVT; i++) begin
               if (evts[ORD_A[i]] && (cfg[ACT_W*ORD_A[i] +: ACT_W] != ACT_KEEP))
                  win_code = cfg[ACT_W*ORD_A[i] +: ACT_W];
            end
         end
      end
   endgenerate

   always_comb begin
      unique case (win_code)
         ACT_FLIP: level_nxt = ~level;
         ACT_LOW:  level_nxt = 1'b0;
         ACT_HIGH: level_nxt = 1'b1;
         default:  level_nxt = level;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= 1'b0;
      else        level <= level_nxt;
   end
endmodule

// File: rtl/pwm_evgen.sv
module pwm_evgen
   import pwm_evgen_pkg::*;
#(
   parameter bit CMPB_FIRST = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_updown,
   input  logic             dir_up,
   input  logic             evt_zero,
   input  logic             evt_load,
   input  logic             evt_cmpa,
   input  logic             evt_cmpb,
   input  logic [CFG_W-1:0] cfg_a,
   input  logic [CFG_W-1:0] cfg_b,
   output logic             pwm_a,
   output logic             pwm_b
);
   if (ACT_W != 2)            $error("pwm_evgen: action codes must be 2 bits");
   if (CFG_W != NUM_EVT * 2)  $error("pwm_evgen: action word width mismatch");
   if (NUM_OUT != 2)          $error("pwm_evgen: exactly two outputs supported");

   evt_vec_t evts;
   cfg_t     cfg_arr [NUM_OUT];
   logic     lvl_arr [NUM_OUT];

   assign cfg_arr[0] = cfg_a;
   assign cfg_arr[1] = cfg_b;

   pwm_evgen_qual i_qual (
      .mode_updown (mode_updown),
      .dir_up      (dir_up),
      .evt_zero    (evt_zero),
      .evt_load    (evt_load),
      .evt_cmpa    (evt_cmpa),
      .evt_cmpb    (evt_cmpb),
      .evts        (evts)
   );

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
      pwm_evgen_chan #(.CMPB_FIRST(CMPB_FIRST)) i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .evts  (evts),
         .cfg   (cfg_arr[g]),
         .level (lvl_arr[g])
      );
   end

   assign pwm_a = lvl_arr[0];
   assign pwm_b = lvl_arr[1];
endmodule

// File: rtl/pwm_evgen_chk.sv
module pwm_evgen_chk
   import pwm_evgen_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             mode_updown,
   input logic             dir_up,
   input logic             evt_zero,
   input logic             evt_load,
   input logic             evt_cmpa,
   input logic             evt_cmpb,
   input logic [CFG_W-1:0] cfg_a,
   input logic [CFG_W-1:0] cfg_b,
   input logic             pwm_a,
   input logic             pwm_b
);
   logic any_evt;
   assign any_evt = evt_zero | evt_load | evt_cmpa | evt_cmpb;

   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |-> (!pwm_a && !pwm_b));                                   // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_evt |=> (pwm_a == $past(pwm_a) && pwm_b == $past(pwm_b)));  // R9

   AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_zero && !evt_load && !evt_cmpa && !evt_cmpb && cfg_b[1:0] == 2'b11)
      |=> pwm_b);                                                      // R2

   AST_DOWNONLY_UPFIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_updown && evt_cmpa && !evt_cmpb && !evt_load && !evt_zero
       && cfg_a[7:6] == 2'b00) |=> $stable(pwm_a));                     // R5

   AST_UP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_updown && dir_up && evt_cmpa && !evt_cmpb && !evt_load && !evt_zero
       && cfg_a[5:4] == 2'b01) |=> (pwm_a != $past(pwm_a)));            // R4
endmodule

bind pwm_evgen pwm_evgen_chk i_chk (
   .clk(clk), .rst_n(rst_n), .mode_updown(mode_updown), .dir_up(dir_up),
   .evt_zero(evt_zero), .evt_load(evt_load), .evt_cmpa(evt_cmpa),
   .evt_cmpb(evt_cmpb), .cfg_a(cfg_a), .cfg_b(cfg_b),
   .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/test_pwm_evgen.sv
`timescale 1ns/1ps
module test_pwm_evgen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_updown = 1'b0, dir_up = 1'b0;
   logic        evt_zero = 1'b0, evt_load = 1'b0, evt_cmpa = 1'b0, evt_cmpb = 1'b0;
   logic [11:0] cfg_a = '0, cfg_b = '0;
   logic        pwm_a, pwm_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwm_evgen i_pwm_evgen (
      .clk(clk), .rst_n(rst_n), .mode_updown(mode_updown), .dir_up(dir_up),
      .evt_zero(evt_zero), .evt_load(evt_load), .evt_cmpa(evt_cmpa),
      .evt_cmpb(evt_cmpb), .cfg_a(cfg_a), .cfg_b(cfg_b),
      .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   localparam logic [1:0] N = 2'b00, T = 2'b01, L = 2'b10, H = 2'b11;

   // field order from bit 0: zero, load, A up, A down, B up, B down (R3)
   function automatic logic [11:0] cf(logic [1:0] z, logic [1:0] l, logic [1:0] au,
                                      logic [1:0] ad, logic [1:0] bu, logic [1:0] bd);
      return {bd, bu, ad, au, l, z};
   endfunction

   typedef struct packed {
      logic        md, dr, z, l, a, b;
      logic [11:0] ca, cb;
      logic        ea, eb;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, cf(H,N,N,N,N,N), cf(N,N,N,N,N,N), 1'b1,1'b0, 4'd2}, // R2 high
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, cf(N,L,N,N,N,N), cf(N,T,N,N,N,N), 1'b0,1'b1, 4'd2}, // R2 low/flip
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, cf(H,H,H,H,H,H), cf(L,L,L,L,L,L), 1'b0,1'b1, 4'd9}, // R9 hold
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, cf(N,N,H,L,N,N), cf(N,N,N,N,N,N), 1'b1,1'b1, 4'd4}, // R4 up
      '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, cf(N,N,H,L,N,N), cf(N,N,N,N,N,N), 1'b0,1'b1, 4'd4}, // R4 down
      '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, cf(N,N,H,N,N,N), cf(N,N,N,N,N,N), 1'b0,1'b1, 4'd5}, // R5 up field unused
      '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, cf(N,N,N,H,N,N), cf(N,N,N,N,N,N), 1'b1,1'b1, 4'd5}, // R5 down field used
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, cf(H,L,N,N,N,N), cf(L,N,N,N,N,N), 1'b0,1'b0, 4'd7}, // R7 load>zero, R8 on B
      '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, cf(N,L,N,H,N,N), cf(N,N,N,N,N,N), 1'b1,1'b0, 4'd7}, // R7 cmp>load
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, cf(N,N,N,L,N,H), cf(N,N,N,H,N,L), 1'b0,1'b1, 4'd7}, // R7 A>B, R6
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, cf(N,N,N,N,N,T), cf(N,N,N,N,N,T), 1'b1,1'b0, 4'd2}, // R2 flip on B down
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, cf(N,N,N,N,L,N), cf(N,N,N,N,H,N), 1'b0,1'b1, 4'd3}, // R3 B up field
      '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, cf(T,N,N,N,N,N), cf(N,N,N,N,N,N), 1'b1,1'b1, 4'd8}  // R8 keep drops out
   };

   task automatic chk(logic act, logic exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic clr_evts();
      evt_zero = 1'b0; evt_load = 1'b0; evt_cmpa = 1'b0; evt_cmpb = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(pwm_a, 1'b0, "R1 reset A");
      chk(pwm_b, 1'b0, "R1 reset B");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         mode_updown = VEC[i].md; dir_up = VEC[i].dr;
         evt_zero = VEC[i].z; evt_load = VEC[i].l;
         evt_cmpa = VEC[i].a; evt_cmpb = VEC[i].b;
         cfg_a = VEC[i].ca; cfg_b = VEC[i].cb;
         @(negedge clk);
         clr_evts();
         chk(pwm_a, VEC[i].ea, $sformatf("R%0d vec%0d A", VEC[i].req, i));
         chk(pwm_b, VEC[i].eb, $sformatf("R%0d vec%0d B", VEC[i].req, i));
      end

      // R1: asynchronous reset while both outputs are high
      #1 rst_n = 1'b0;
      #0.5;
      chk(pwm_a, 1'b0, "R1 async A");
      chk(pwm_b, 1'b0, "R1 async B");
      @(negedge clk);
      rst_n = 1'b1;

      // R10: center-aligned waveform from an up/down counter, load 7, compare 3
      begin
         int  c = 0;
         bit  up = 1'b1;
         bit  exp = 1'b0;
         int  highs = 0;
         mode_updown = 1'b1;
         cfg_a = cf(N,N,H,L,N,N);
         cfg_b = cf(N,N,N,N,N,N);
         for (int k = 0; k < 28; k++) begin
            chk(pwm_a, exp, $sformatf("R10 cycle%0d", k));
            if (pwm_a) highs++;
            dir_up   = up;
            evt_zero = (c == 0);
            evt_load = (c == 7);
            evt_cmpa = (c == 3);
            if (c == 3) exp = up;
            if (up) begin c++; if (c == 7) up = 1'b0; end
            else    begin c--; if (c == 0) up = 1'b1; end
            @(negedge clk);
         end
         clr_evts();
         checks++;
         if (highs != 16) begin
            errors++;
            $display("FAIL R10 high count: actual=%0d expected=16", highs);
         end
         chk(pwm_b, 1'b0, "R6 B untouched by A events");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule